// File: doc/BRIEF.md
# Multi-Mode Interval Timer Core

This block is a 16-bit timer counter for an interval and waveform timing subsystem. A tick is produced from one of four source enable pulses, all in the block's single clock domain. The chosen pulse stream is divided by 1, 2, 4 or 8 before it reaches the counter. The counter then stops, counts up to a period value, runs freely up to a length-dependent maximum, or runs up and down between zero and the period value.

Every return of the count to zero sets a sticky wrap flag, and the flag raises an interrupt request when it is enabled. Two single-tick strobes, one for "count equals period" and one for "count equals zero", go to the compare output units that sit beside the core. A small write port lets software load the count and the period, clear the counter, and clear the flag.

The direction of the up/down mode is kept in a two-state machine. In state ST_UP the counter increments; the transition ST_UP to ST_DOWN is taken when the count reaches the period. In state ST_DOWN the counter decrements; the transition ST_DOWN to ST_UP is taken on the step that lands on zero. A clear, or any mode other than up/down, forces the machine to ST_UP.

Top module: `tmr_core`

## Requirements
- R1: While `rst_n` is low and after its release, `cnt` is 0, `ovf_flag` is 0, and `irq`, `eq_per` and `eq_zero` are 0 until the first tick.
- R2: `src_sel` picks line `src_pulse[src_sel]`. With `div_sel` = d, a tick happens on every 2^d-th pulse of that line, counted by a 3-bit pulse counter. The pulse counter is reset only by `clr`, and only ticks move the count.
- R3: Mode 2'b00 (stop) holds `cnt` on every tick.
- R4: Mode 2'b01 (up): on a tick, `cnt` increments while it is below the period; when it is at or above the period, it returns to 0 and sets `ovf_flag`.
- R5: Mode 2'b10 (continuous): on a tick, `cnt` increments; when it is at or above the length maximum, it wraps to 0 and sets `ovf_flag`.
- R6: Mode 2'b11 (up/down): the count rises to the period and then falls; the step from 1 to 0 sets `ovf_flag` and turns the direction back up, so one cycle lasts 2×period ticks.
- R7: A period of 0 halts the count in up and up/down modes but not in continuous mode.
- R8: `len_sel` sets the maximum: 00→0xFFFF, 01→0x0FFF, 10→0x03FF, 11→0x00FF. A count write is masked to that maximum.
- R9: `clr` zeroes the count, resets the pulse counter and sets the direction to up, with priority over a count write. `wr_cnt` loads `wr_data` and has priority over a tick.
- R10: `ovf_flag` stays set until `flag_clr`; a wrap in the same cycle wins over the clear. `irq` = `ovf_flag` AND `irq_en`.
- R11: `eq_per` / `eq_zero` are high during a tick cycle, in any mode but stop, when `cnt` equals the period or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 4 | Source enable pulses |
| src_sel | input | 2 | Source select |
| div_sel | input | 2 | Prescale exponent |
| mode | input | 2 | Count mode |
| len_sel | input | 2 | Counter length |
| clr | input | 1 | Clear pulse |
| wr_cnt | input | 1 | Load count from wr_data |
| wr_per | input | 1 | Load period from wr_data |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clear the wrap flag |
| irq_en | input | 1 | Interrupt enable |
| cnt | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Interrupt request |
| eq_per | output | 1 | Count-equals-period strobe |
| eq_zero | output | 1 | Count-equals-zero strobe |

## Verification
The hardest condition to reach from the ports is the full-length continuous wrap at 0xFFFF, together with up/down turnarounds that start from an odd state. The stimulus loads the count just below each maximum through the write port, so the wrap comes within a few ticks. It also lowers the period below the running count, and clears the counter while it is falling. Random pulses on all four source lines, with every divide setting, test that only the selected line advances the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        M_STOP = 2'b00,
        M_UP   = 2'b01,
        M_CONT = 2'b10,
        M_UPDN = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } tmr_dir_e;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSRC-1:0]  src_pulse,
    input  logic [SEL_W-1:0] src_sel,
    output logic             pulse
);
    always_comb begin
        pulse = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (SEL_W'(i) == src_sel) pulse = src_pulse[i];
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       pulse,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = PRE_W'((1 << div_sel) - 1);
        tick = pulse && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else if (pulse)    pre_q <= pre_q + PRE_W'(1);
    end

    // R2: with no source pulse and no clear, the divider must not move
    p_pre_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [1:0]       len_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             clr,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             eq_per,
    output logic             eq_zero
);
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    tmr_mode_e        mode_e;
    tmr_dir_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_max;

    assign mode_e = tmr_mode_e'(mode);

    always_comb begin
        unique case (len_sel)
            2'd0: cnt_max = ONES;
            2'd1: cnt_max = ONES >> 4;
            2'd2: cnt_max = ONES >> 6;
            default: cnt_max = ONES >> 8;
        endcase
    end

    // next-state and count process
    always_comb begin
        cnt_d = cnt_q;
        st_d  = st_q;
        wrap  = 1'b0;
        if (mode_e != M_UPDN) st_d = ST_UP;
        if (clr) begin
            cnt_d = '0;
            st_d  = ST_UP;
        end else if (wr_cnt) begin
            cnt_d = wr_data & cnt_max;
        end else if (tick) begin
            unique case (mode_e)
                M_STOP: cnt_d = cnt_q;
                M_UP: begin
                    if (period != '0) begin
                        if (cnt_q >= period) begin
                            cnt_d = '0;
                            wrap  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                end
                M_CONT: begin
                    if (cnt_q >= cnt_max) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                M_UPDN: begin
                    if (period != '0) begin
                        unique case (st_q)
                            ST_UP: begin
                                if (cnt_q >= period) begin
                                    if (cnt_q <= ONE) begin
                                        cnt_d = '0;
                                        wrap  = (cnt_q == ONE);
                                        st_d  = ST_UP;
                                    end else begin
                                        cnt_d = cnt_q - ONE;
                                        st_d  = ST_DOWN;
                                    end
                                end else begin
                                    cnt_d = cnt_q + ONE;
                                end
                            end
                            ST_DOWN: begin
                                if (cnt_q <= ONE) begin
                                    cnt_d = '0;
                                    wrap  = (cnt_q == ONE);
                                    st_d  = ST_UP;
                                end else begin
                                    cnt_d = cnt_q - ONE;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output process
    always_comb begin
        cnt     = cnt_q;
        eq_per  = tick && (mode_e != M_STOP) && (cnt_q == period);
        eq_zero = tick && (mode_e != M_STOP) && (cnt_q == '0);
    end

    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == M_STOP && !clr && !wr_cnt) |=> $stable(cnt_q));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    p_down_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DOWN && mode_e == M_UPDN && tick && period != '0
         && cnt_q > ONE && !clr && !wr_cnt) |=> (cnt_q == $past(cnt_q) - ONE));

    p_per_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_e == M_UP || mode_e == M_UPDN) && period == '0 && !clr && !wr_cnt)
        |=> $stable(cnt_q));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && st_q == ST_UP));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4,
    parameter int PRE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          src_pulse,
    input  logic [$clog2(NSRC)-1:0]  src_sel,
    input  logic [1:0]               div_sel,
    input  logic [1:0]               mode,
    input  logic [1:0]               len_sel,
    input  logic                     clr,
    input  logic                     wr_cnt,
    input  logic                     wr_per,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic                     flag_clr,
    input  logic                     irq_en,
    output logic [CNT_W-1:0]         cnt,
    output logic                     ovf_flag,
    output logic                     irq,
    output logic                     eq_per,
    output logic                     eq_zero
);
    localparam int SEL_W = $clog2(NSRC);

    logic             sel_pulse, tick, wrap;
    logic [CNT_W-1:0] per_q;
    logic             flag_q;

    tmr_src_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_src (
        .src_pulse(src_pulse), .src_sel(src_sel), .pulse(sel_pulse)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pulse(sel_pulse),
        .div_sel(div_sel), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .len_sel(len_sel),
        .period(per_q), .clr(clr), .wr_cnt(wr_cnt), .wr_data(wr_data),
        .cnt(cnt), .wrap(wrap), .eq_per(eq_per), .eq_zero(eq_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_per) per_q <= wr_data;
            if (wrap)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q & irq_en;

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    p_flag_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt == '0));
endmodule

// File: tb/test_tmr_core.sv
module test_tmr_core;
    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n;
    logic [3:0]  src_pulse;
    logic [1:0]  src_sel, div_sel, mode, len_sel;
    logic        clr, wr_cnt, wr_per, flag_clr, irq_en;
    logic [15:0] wr_data;
    logic [15:0] cnt;
    logic        ovf_flag, irq, eq_per, eq_zero;

    tmr_core i_tmr_core (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .src_sel(src_sel),
        .div_sel(div_sel), .mode(mode), .len_sel(len_sel), .clr(clr),
        .wr_cnt(wr_cnt), .wr_per(wr_per), .wr_data(wr_data), .flag_clr(flag_clr),
        .irq_en(irq_en), .cnt(cnt), .ovf_flag(ovf_flag), .irq(irq),
        .eq_per(eq_per), .eq_zero(eq_zero)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    m_cnt, m_per, m_pre, m_flag;
    bit    m_down;
    int    n_chk, n_fail;
    string cur_req;
    int    src_kind;

    function automatic int len_max(input int l);
        case (l)
            0: return 65535;
            1: return 4095;
            2: return 1023;
            default: return 255;
        endcase
    endfunction

    function automatic bit exp_tick();
        int d;
        d = 1 << div_sel;
        return src_pulse[src_sel] && ((m_pre % d) == d - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        bit t, ep, ez, ei;
        t  = exp_tick();
        ep = t && mode != 2'd0 && m_cnt == m_per;
        ez = t && mode != 2'd0 && m_cnt == 0;
        ei = m_flag != 0 && irq_en;
        chk(cnt == 16'(m_cnt), cur_req, "count", int'(cnt), m_cnt);
        chk(ovf_flag == (m_flag != 0), cur_req, "flag", int'(ovf_flag), m_flag);
        chk(irq == ei, "R10", "irq", int'(irq), int'(ei));
        chk(eq_per == ep, "R11", "eq_per", int'(eq_per), int'(ep));
        chk(eq_zero == ez, "R11", "eq_zero", int'(eq_zero), int'(ez));
    endtask

    // behavioural reference, evaluated at each rising edge from the applied inputs
    task automatic model_edge();
        bit t, wr;
        int mx;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_pre = 0; m_flag = 0; m_down = 0;
            return;
        end
        t  = exp_tick();
        wr = 0;
        mx = len_max(int'(len_sel));
        if (mode != 2'd3) m_down = 0;
        if (clr) begin
            m_cnt = 0; m_pre = 0; m_down = 0;
        end else begin
            if (src_pulse[src_sel]) m_pre = (m_pre + 1) % 8;
            if (wr_cnt) m_cnt = int'(wr_data) & mx;
            else if (t) begin
                case (mode)
                    2'd1: if (m_per != 0) begin
                        if (m_cnt >= m_per) begin m_cnt = 0; wr = 1; end
                        else m_cnt++;
                    end
                    2'd2: if (m_cnt >= mx) begin m_cnt = 0; wr = 1; end
                          else m_cnt++;
                    2'd3: if (m_per != 0) begin
                        if (!m_down && m_cnt < m_per) m_cnt++;
                        else if (m_cnt <= 1) begin
                            wr = (m_cnt == 1); m_cnt = 0; m_down = 0;
                        end else begin
                            m_cnt--; m_down = 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (wr_per) m_per = int'(wr_data);
        if (wr) m_flag = 1;
        else if (flag_clr) m_flag = 0;
    endtask

    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            if (src_kind == 0) src_pulse = 4'($urandom);
            else src_pulse = 4'hF;
            step();
        end
        src_pulse = 4'h0;
    endtask

    task automatic set_period(input int v);
        wr_per = 1; wr_data = 16'(v); step(); wr_per = 0;
    endtask

    task automatic load_count(input int v);
        wr_cnt = 1; wr_data = 16'(v); step(); wr_cnt = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        n_chk = 0; n_fail = 0; src_kind = 1;
        rst_n = 0; src_pulse = 0; src_sel = 0; div_sel = 0; mode = 0; len_sel = 0;
        clr = 0; wr_cnt = 0; wr_per = 0; wr_data = 0; flag_clr = 0; irq_en = 0;
        cur_req = "R1";
        @(posedge clk); model_edge(); @(negedge clk);
        step(); step();
        rst_n = 1;
        step(); step();

        // R2: source select and divide, random pulses on all lines
        cur_req = "R2"; src_kind = 0; mode = 2'd2; len_sel = 2'd3;
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                src_sel = 2'(s); div_sel = 2'(d);
                run(40);
            end
        end
        clr = 1; step(); clr = 0;

        // R3: stop mode holds
        cur_req = "R3"; mode = 2'd0; src_kind = 1; div_sel = 0; src_sel = 1;
        load_count(7);
        run(20);

        // R4: up mode with period 5, flag and irq handling (R10)
        cur_req = "R4"; len_sel = 0; mode = 2'd1;
        set_period(5);
        load_count(0);
        irq_en = 1;
        run(30);
        cur_req = "R10"; flag_clr = 1; run(3); flag_clr = 0; irq_en = 0; run(8);
        irq_en = 1; flag_clr = 1; run(12); flag_clr = 0;
        // period lowered below running count
        cur_req = "R4"; load_count(9); run(6);

        // R5 and R8: continuous mode at each length
        cur_req = "R5"; mode = 2'd2; len_sel = 2'd3; load_count(250); run(300);
        cur_req = "R8";
        len_sel = 2'd2; load_count(1020); run(10);
        len_sel = 2'd1; load_count(4093); run(10);
        len_sel = 2'd0; load_count(65532); run(10);
        len_sel = 2'd3; load_count(16'h1234); run(4);
        len_sel = 2'd2; load_count(16'hFFFF); run(4);

        // R6: up/down with several periods and divides
        cur_req = "R6"; len_sel = 0; mode = 2'd3; clr = 1; step(); clr = 0;
        set_period(4); run(30);
        set_period(1); run(10);
        set_period(3); div_sel = 1; run(40); div_sel = 0;
        load_count(10); run(25);

        // R9: clear while falling, write priorities
        cur_req = "R9"; set_period(6); clr = 1; step(); clr = 0;
        run(9);
        clr = 1; src_pulse = 4'hF; step(); clr = 0;
        run(5);
        clr = 1; wr_cnt = 1; wr_data = 16'd40; src_pulse = 4'hF; step();
        clr = 0; wr_cnt = 0;
        wr_cnt = 1; wr_data = 16'd3; src_pulse = 4'hF; step(); wr_cnt = 0;
        run(6);

        // R7: zero period halts up and up/down but not continuous
        cur_req = "R7"; load_count(2); set_period(0);
        mode = 2'd3; run(8);
        mode = 2'd1; run(8);
        mode = 2'd2; run(8);

        // R11: strobes under random pulses in all counting modes
        cur_req = "R11"; src_kind = 0; set_period(3);
        for (int m = 1; m < 4; m++) begin
            mode = 2'(m); len_sel = 2'd3; div_sel = 2'(m - 1); run(50);
        end

        finish_up();
    end
endmodule